// File: doc/BRIEF.md
# Header-Check Cell Delineator

This block finds cell boundaries in a received byte stream built from fixed 53-byte cells. Each cell carries a 5-byte header whose last byte is a CRC-8 check over the first four. The block keeps the most recent bytes in a shift window. It tests each candidate header against the check rule and moves through three phases: searching (HUNT), confirming (PRESYNC) and locked (SYNC). Hysteresis keeps noise from making or breaking lock. `DELTA` confirmed headers are needed to lock, and `ALPHA` consecutive bad headers are needed to lose lock.

When the block is locked, it marks each cell that has a valid header. It does this with a strobe and the 32-bit header word on the byte that completes the header. It then forwards that cell's 48 payload bytes. Cells with a bad header are dropped whole. Upstream logic supplies octet-aligned bytes with a qualifier. Byte positions count only the bytes that are accepted.

Top module: `cd_delineator`

## Requirements
- R1: After reset the block is in HUNT. `in_sync`, `cell_start` and `out_valid` are low until a header is confirmed.
- R2: A candidate header is the four previously accepted bytes followed by the current byte. It is good when the fifth byte equals the CRC-8 of the first four XOR 0x55. The CRC uses generator x^8+x^2+x+1, a zero preset, and the most significant bit first. In HUNT a candidate is tested on every accepted byte, once four bytes have been accepted since reset. The first good candidate moves the block to PRESYNC. Every byte offset is reachable.
- R3: Outside HUNT, the block tests only the byte that is 53 accepted bytes after the previous test. All bytes in between are skipped.
- R4: A failed test in PRESYNC returns the block to HUNT. The search resumes with the next accepted byte.
- R5: The DELTA-th consecutive passing test in PRESYNC enters SYNC. `in_sync` is high from the next byte onward.
- R6: In SYNC, `cell_start` pulses on the byte that completes a good header, with `out_hdr` holding its first four bytes. A bad header produces no strobe and no payload output. Fewer than ALPHA consecutive bad headers keep SYNC, and a good header clears the run.
- R7: ALPHA consecutive bad headers in SYNC return the block to HUNT. `in_sync` is low from the next byte.
- R8: After a `cell_start`, the next 48 accepted bytes appear with `out_valid` high and `out_byte` equal to `in_byte`.
- R9: A cycle with `in_valid` low changes no state and produces no `cell_start` or `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte qualifier |
| in_byte | input | 8 | Received byte |
| in_sync | output | 1 | Locked (SYNC phase) |
| cell_start | output | 1 | Good header completes on this byte |
| out_hdr | output | 32 | First four header bytes, valid with `cell_start` |
| out_valid | output | 1 | Forwarded payload byte |
| out_byte | output | 8 | Payload byte |

## Verification
The hardest case to reach is a search that starts at an arbitrary byte offset without being misled by a false header match. The stimulus picks a header value whose every shifted 5-byte window fails the check against surrounding zero bytes. It then sweeps the leading garbage length over all 53 offsets, so the lock byte is known exactly. A separate run inserts stall cycles carrying a tempting value, to show that only accepted bytes move the search.

// File: rtl/cd_pkg.sv
package cd_pkg;
   typedef enum logic [1:0] {ST_HUNT, ST_PRESYNC, ST_SYNC} dl_state_e;

   localparam int CELL_BYTES = 53;
   localparam int HDR_BYTES  = 5;

   // one byte of CRC-8, generator x^8+x^2+x+1, msb first
   function automatic logic [7:0] crc8_byte(input logic [7:0] crc_in, input logic [7:0] d);
      logic [7:0] c;
      logic       fb;
      c = crc_in;
      for (int i = 7; i >= 0; i--) begin
         fb = c[7] ^ d[i];
         c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
      return c;
   endfunction
endpackage

// File: rtl/cd_hec_check.sv
module cd_hec_check #(
   parameter int         NB    = 4,
   parameter logic [7:0] COSET = 8'h55
) (
   input  logic [8*(NB+1)-1:0] cand,
   output logic                ok
);
   import cd_pkg::*;

   if (NB < 1) begin : g_bad_nb
      $error("cd_hec_check: NB must be at least 1");
   end

   logic [7:0] crc_s [0:NB];
   assign crc_s[0] = 8'h00;

   for (genvar i = 0; i < NB; i++) begin : g_stage
      assign crc_s[i+1] = crc8_byte(crc_s[i], cand[8*(NB+1)-1-8*i -: 8]);
   end

   assign ok = ((crc_s[NB] ^ COSET) == cand[7:0]);
endmodule

// File: rtl/cd_window.sv
module cd_window #(
   parameter int NB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift,
   input  logic [7:0]    din,
   output logic [8*NB-1:0] hist,
   output logic          full
);
   localparam int FW = $clog2(NB + 1);
   localparam logic [FW-1:0] FILL_MAX = FW'(NB);

   logic [FW-1:0] fill;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist <= '0;
         fill <= '0;
      end else if (shift) begin
         if (NB > 1) hist <= {hist[8*NB-9:0], din};
         else        hist <= din;
         if (fill != FILL_MAX) fill <= fill + 1'b1;
      end
   end

   assign full = (fill == FILL_MAX);

   // R2: once four bytes are held, the window stays armed until reset
   p_fill_keep_r2: assert property (@(posedge clk) disable iff (!rst_n) full |=> full);
endmodule

// File: rtl/cd_delineator.sv
module cd_delineator #(
   parameter int         ALPHA = 7,
   parameter int         DELTA = 6,
   parameter logic [7:0] COSET = 8'h55
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [7:0]  in_byte,
   output logic        in_sync,
   output logic        cell_start,
   output logic [31:0] out_hdr,
   output logic        out_valid,
   output logic [7:0]  out_byte
);
   import cd_pkg::*;

   localparam int NB    = HDR_BYTES - 1;
   localparam int CNT_W = 4;
   localparam int POS_W = $clog2(CELL_BYTES);
   localparam int PAY   = CELL_BYTES - HDR_BYTES;
   localparam logic [POS_W-1:0] LAST = POS_W'(CELL_BYTES - 1);
   localparam logic [CNT_W:0]   A_LIM = (CNT_W+1)'(ALPHA);
   localparam logic [CNT_W:0]   D_LIM = (CNT_W+1)'(DELTA);

   if (ALPHA < 1 || ALPHA > 15) begin : g_bad_alpha
      $error("cd_delineator: ALPHA out of range 1..15");
   end
   if (DELTA < 1 || DELTA > 15) begin : g_bad_delta
      $error("cd_delineator: DELTA out of range 1..15");
   end

   dl_state_e        state, st_n;
   logic [POS_W-1:0] pos, pos_n;
   logic [CNT_W-1:0] good, good_n, bad, bad_n;
   logic             keep, keep_n;
   logic [8*NB-1:0]  hist;
   logic             full, hdr_ok, at_hdr;
   logic [CNT_W:0]   good_inc, bad_inc;

   cd_window #(.NB(NB)) u_win (
      .clk(clk), .rst_n(rst_n), .shift(in_valid), .din(in_byte),
      .hist(hist), .full(full)
   );

   cd_hec_check #(.NB(NB), .COSET(COSET)) u_chk (
      .cand({hist, in_byte}), .ok(hdr_ok)
   );

   assign at_hdr   = (pos == LAST);
   assign good_inc = {1'b0, good} + 1'b1;
   assign bad_inc  = {1'b0, bad} + 1'b1;

   always_comb begin
      st_n   = state;
      pos_n  = pos;
      good_n = good;
      bad_n  = bad;
      keep_n = keep;
      if (in_valid) begin
         unique case (state)
            ST_HUNT: begin
               if (full && hdr_ok) begin
                  st_n   = ST_PRESYNC;
                  pos_n  = '0;
                  good_n = '0;
               end
            end
            ST_PRESYNC: begin
               pos_n = pos + 1'b1;
               if (at_hdr) begin
                  pos_n = '0;
                  if (!hdr_ok) begin
                     st_n = ST_HUNT;
                  end else if (good_inc == D_LIM) begin
                     st_n   = ST_SYNC;
                     bad_n  = '0;
                     keep_n = 1'b0;
                  end else begin
                     good_n = good_inc[CNT_W-1:0];
                  end
               end
            end
            default: begin
               pos_n = pos + 1'b1;
               if (at_hdr) begin
                  pos_n = '0;
                  if (hdr_ok) begin
                     bad_n  = '0;
                     keep_n = 1'b1;
                  end else begin
                     keep_n = 1'b0;
                     if (bad_inc == A_LIM) st_n = ST_HUNT;
                     else                  bad_n = bad_inc[CNT_W-1:0];
                  end
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_HUNT;
         pos   <= '0;
         good  <= '0;
         bad   <= '0;
         keep  <= 1'b0;
      end else begin
         state <= st_n;
         pos   <= pos_n;
         good  <= good_n;
         bad   <= bad_n;
         keep  <= keep_n;
      end
   end

   assign in_sync    = (state == ST_SYNC);
   assign cell_start = in_valid && in_sync && at_hdr && hdr_ok;
   assign out_hdr    = cell_start ? hist : '0;
   assign out_valid  = in_valid && in_sync && keep && (int'(pos) < PAY);
   assign out_byte   = out_valid ? in_byte : 8'h00;

   // R3: position counter never leaves the cell
   p_pos_bound_r3: assert property (@(posedge clk) disable iff (!rst_n) pos <= LAST);
   // R4: failed confirmation drops back to search
   p_presync_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PRESYNC && in_valid && at_hdr && !hdr_ok) |=> state == ST_HUNT);
   // R5: lock is only ever entered from confirmation
   p_lock_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_sync) |-> $past(state == ST_PRESYNC));
   // R7: locked never falls back into confirmation
   p_no_sync_to_pre_r7: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_SYNC |=> state != ST_PRESYNC);
   // R9: stalls hold all tracking state
   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(state) && $stable(pos) && $stable(bad) && $stable(good));
endmodule

// File: tb/cd_delineator_test.sv
module cd_delineator_test;
   localparam int A = 2;
   localparam int D = 3;

   logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic in_sync, cell_start, out_valid;
   logic [31:0] out_hdr;
   logic [7:0] out_byte;

   cd_delineator #(.ALPHA(A), .DELTA(D)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_sync(in_sync), .cell_start(cell_start), .out_hdr(out_hdr),
      .out_valid(out_valid), .out_byte(out_byte)
   );

   always #10 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   int vidx, first_start, first_sync, drop_idx, n_start, n_pay, pay_err, stall_err;
   bit was_sync, gap_en;
   logic [31:0] last_hdr, hdr;
   logic [7:0]  hec;

   task automatic check(input bit c, input string req, input longint act, input longint exp);
      n_chk++;
      if (!c) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] hec_of(input logic [31:0] h);
      logic [39:0] r;
      r = {h, 8'h00};
      for (int i = 39; i >= 8; i--)
         if (r[i]) r = r ^ (40'h107 << (i - 8));
      return r[7:0] ^ 8'h55;
   endfunction

   function automatic bit win_ok(input logic [39:0] w);
      return hec_of(w[39:8]) == w[7:0];
   endfunction

   function automatic bit clean(input logic [31:0] h);
      logic [7:0] s [0:12];
      for (int i = 0; i < 13; i++) s[i] = 8'h00;
      s[4] = h[31:24]; s[5] = h[23:16]; s[6] = h[15:8]; s[7] = h[7:0]; s[8] = hec_of(h);
      for (int e = 4; e <= 12; e++)
         if (e != 8 && win_ok({s[e-4], s[e-3], s[e-2], s[e-1], s[e]})) return 1'b0;
      return 1'b1;
   endfunction

   task automatic put(input logic [7:0] b, input bit v);
      @(negedge clk);
      in_valid = v;
      in_byte  = b;
      #5;
      if (!v) begin
         if (cell_start || out_valid) stall_err++;
      end else begin
         if (cell_start) begin
            n_start++;
            if (first_start < 0) first_start = vidx;
            last_hdr = out_hdr;
         end
         if (in_sync) begin
            if (first_sync < 0) first_sync = vidx;
            was_sync = 1'b1;
         end else if (was_sync && drop_idx < 0) begin
            drop_idx = vidx;
         end
         if (out_valid) begin
            n_pay++;
            if (out_byte != b) pay_err++;
         end
         vidx++;
      end
   endtask

   task automatic pb(input logic [7:0] b);
      if (gap_en && (vidx % 3 == 0)) put(8'h55, 1'b0);
      put(b, 1'b1);
   endtask

   task automatic send_cell(input bit good, input bit pat);
      pb(good ? hdr[31:24] : 8'h00);
      pb(good ? hdr[23:16] : 8'h00);
      pb(good ? hdr[15:8]  : 8'h00);
      pb(good ? hdr[7:0]   : 8'h00);
      pb(good ? hec        : 8'h00);
      for (int i = 0; i < 48; i++) pb(pat ? 8'(i * 7 + 3) : 8'h00);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0;
      repeat (2) @(negedge clk);
      vidx = 0; first_start = -1; first_sync = -1; drop_idx = -1;
      n_start = 0; n_pay = 0; pay_err = 0; stall_err = 0; was_sync = 1'b0;
      rst_n = 1'b1;
   endtask

   initial begin
      #(20 * 150000);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      gap_en = 1'b0;
      hdr = 32'h00A1_B2C0;
      while (!clean(hdr)) hdr = hdr + 1;
      hec = hec_of(hdr);

      // R1: reset state
      do_reset();
      put(8'h00, 1'b0);
      check(!in_sync && !cell_start && !out_valid, "R1 reset outputs",
            {in_sync, cell_start, out_valid}, 0);

      // R2 R3 R5: sweep every byte offset of the first header
      for (int g = 0; g < 53; g++) begin
         do_reset();
         for (int k = 0; k < g; k++) pb(8'h00);
         for (int c = 0; c < D + 2; c++) send_cell(1'b1, 1'b0);
         check(first_start == g + 53 * (D + 1) + 4, "R2 R3 first cell_start index",
               first_start, g + 53 * (D + 1) + 4);
         check(first_sync == g + 53 * D + 5, "R5 lock index", first_sync, g + 53 * D + 5);
         check(n_start == 1, "R3 strobe count", n_start, 1);
      end

      // R4: failed confirmation restarts the search
      do_reset();
      for (int k = 0; k < 7; k++) pb(8'h00);
      send_cell(1'b1, 1'b0);
      send_cell(1'b0, 1'b0);
      for (int c = 0; c < D + 2; c++) send_cell(1'b1, 1'b0);
      check(first_start == 7 + 53 * (3 + D) + 4, "R4 restart after presync fail",
            first_start, 7 + 53 * (3 + D) + 4);

      // R6 R8: drops below the threshold, payload forwarding
      do_reset();
      for (int c = 0; c <= D; c++) send_cell(1'b1, 1'b0);
      send_cell(1'b1, 1'b1);
      for (int c = 0; c < A - 1; c++) send_cell(1'b0, 1'b1);
      send_cell(1'b1, 1'b1);
      send_cell(1'b1, 1'b1);
      put(8'h00, 1'b1);
      check(n_start == 3, "R6 strobes around dropped cells", n_start, 3);
      check(in_sync == 1'b1, "R6 lock kept after short bad run", in_sync, 1);
      check(last_hdr == hdr, "R6 out_hdr value", last_hdr, hdr);
      check(n_pay == 3 * 48, "R8 payload byte count", n_pay, 3 * 48);
      check(pay_err == 0, "R8 payload byte value", pay_err, 0);

      // R7: alpha bad headers lose lock
      do_reset();
      for (int c = 0; c <= D + 1; c++) send_cell(1'b1, 1'b0);
      for (int c = 0; c < A; c++) send_cell(1'b0, 1'b0);
      put(8'h00, 1'b1);
      check(drop_idx == 53 * (D + 1 + A) + 5, "R7 lock loss index",
            drop_idx, 53 * (D + 1 + A) + 5);
      check(n_start == 1, "R7 strobe count", n_start, 1);

      // R9: stalls do not advance the search
      do_reset();
      gap_en = 1'b1;
      for (int k = 0; k < 5; k++) pb(8'h00);
      for (int c = 0; c < D + 2; c++) send_cell(1'b1, 1'b1);
      gap_en = 1'b0;
      check(first_start == 5 + 53 * (D + 1) + 4, "R9 start index with stalls",
            first_start, 5 + 53 * (D + 1) + 4);
      check(stall_err == 0, "R9 no output on stall", stall_err, 0);
      check(n_pay == 48 && pay_err == 0, "R9 R8 payload with stalls", n_pay, 48);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule